// File: doc/BRIEF.md
# Round-Key Schedule Generator for a 32-bit, 12-Round RC5 Cipher

This block expands a 128-bit secret key into the 26-word round-key table used by an RC5 cipher with 32-bit words and 12 rounds. A single-cycle strobe captures the whole key over parallel input lines. The block then works through the schedule at one step per clock. First it fills the table with an arithmetic progression of two fixed constants. Then it runs the key-mixing loop with data-dependent rotations. When the loop ends, it raises a ready flag.

The cipher core reads the finished table through a combinational read port: it presents a word index and gets the stored word in the same cycle. A new strobe at any time discards the expansion in progress and starts over with the new key. The key input may change freely once the strobe has been sampled.

Top module: `rc5_key_expander`

## Requirements
- R1: After reset `ready` is 0 and every table index (0 to 31) reads 0 on `rdData`.
- R2: On a clock edge where `setKey` is 1, the key on `keyIn` is captured as four 32-bit words. Key byte n is `keyIn[8n+7:8n]`, and word k is built so that byte 4k is its least significant byte, that is word k = `keyIn[32k+31:32k]`.
- R3: Before mixing, table entry 0 holds 0xB7E15163 and entry i holds entry i-1 plus 0x9E3779B9, modulo 2^32, for i = 1 to 25.
- R4: Mixing starts with A = B = 0 and both indices at 0. It then runs 78 iterations. Each iteration first sets A and table entry i to rotl(S[i]+A+B, 3). It then sets B and key word j to rotl(L[j]+A+B, (A+B) mod 32). Finally i steps modulo 26 and j steps modulo 4. When `ready` is 1, `rdData` equals the table that results.
- R5: `ready` is 0 during the 103 cycles after the edge that samples `setKey`. It goes to 1 on the 104th following edge: 26 fill steps plus 78 mixing steps.
- R6: While `ready` is 1 and no new `setKey` arrives, `ready` stays 1 and every table entry keeps its value.
- R7: A `setKey` sampled while an expansion is in progress abandons that expansion. The table then matches the newest key, and `ready` rises 104 edges after that last strobe.
- R8: Changes on `keyIn` after the edge that sampled `setKey` have no effect on the resulting table.
- R9: Reads at indices 26 to 31 return 0 at all times.
- R10: A `setKey` sampled while `ready` is 1 makes `ready` 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setKey | input | 1 | One-cycle strobe that captures `keyIn` and restarts the schedule |
| keyIn | input | 128 | Secret key, byte n on bits 8n+7 to 8n |
| rdAddr | input | 5 | Table index to read |
| rdData | output | 32 | Table word at `rdAddr`, combinational |
| ready | output | 1 | High once the table is complete |

## Verification
The main corner case is the rotation amount: when (A+B) mod 32 is 0, the rotation must leave the word unchanged. A design that shifts by the full width at that point, or one that takes the amount from B alone, produces a table that differs from the reference model after one or two iterations. The bench aborts expansions twice: once during the table fill and once during mixing. A design that does not reset the pointers or the A and B registers on a new strobe would give a corrupted table. A design that counts from the wrong edge would raise `ready` early or late, and the per-cycle comparison of `ready` catches an error of even one cycle. During one expansion the key input is scrambled on every cycle, which exposes any design that reads the key live instead of from its captured copy. Reads beyond index 25 are checked across every sweep, which exposes an index decoder that aliases them onto real entries.

// File: rtl/rc5ks_pkg.sv
package rc5ks_pkg;
  localparam int WORD_W     = 32;
  localparam int ROUNDS     = 12;
  localparam int KEY_BYTES  = 16;
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int KEY_WORDS  = (KEY_BYTES + BYTES_PER_WORD - 1) / BYTES_PER_WORD;
  localparam int KEY_BITS   = KEY_BYTES * 8;
  localparam int TABLE_N    = 2 * (ROUNDS + 1);
  localparam int MIX_N      = 3 * ((TABLE_N > KEY_WORDS) ? TABLE_N : KEY_WORDS);
  localparam int LATENCY    = TABLE_N + MIX_N;
  localparam int ADDR_W     = $clog2(TABLE_N);
  localparam int ROT_W      = $clog2(WORD_W);
  localparam int JPTR_W     = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
  localparam logic [WORD_W-1:0] P_CONST = 32'hB7E15163;
  localparam logic [WORD_W-1:0] Q_CONST = 32'h9E3779B9;

  typedef struct packed {
    logic load;     // capture key, clear pointers and mix registers
    logic initWr;   // write one progression entry
    logic mixStep;  // perform one mixing iteration
  } ksStrobe_t;
endpackage

// File: rtl/rc5ks_ctrl.sv
module rc5ks_ctrl
  import rc5ks_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      setKey,
  output ksStrobe_t strobe,
  output logic      ready
);
  localparam int CNT_W = $clog2((MIX_N > TABLE_N) ? MIX_N : TABLE_N);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_MIX, ST_DONE} ksState_t;

  ksState_t state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else if (setKey) begin
      state   <= ST_FILL;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_FILL: begin
          if (stepCnt == CNT_W'(TABLE_N - 1)) begin
            state   <= ST_MIX;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_MIX: begin
          if (stepCnt == CNT_W'(MIX_N - 1)) begin
            state   <= ST_DONE;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: stepCnt <= '0;
      endcase
    end
  end

  always_comb begin
    strobe.load    = setKey;
    strobe.initWr  = !setKey && (state == ST_FILL);
    strobe.mixStep = !setKey && (state == ST_MIX);
  end

  assign ready = (state == ST_DONE);
endmodule

// File: rtl/rc5ks_datapath.sv
module rc5ks_datapath
  import rc5ks_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ksStrobe_t           strobe,
  input  logic [KEY_BITS-1:0] keyIn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [WORD_W-1:0]   rdData
);
  logic [WORD_W-1:0] sTab [TABLE_N];
  logic [WORD_W-1:0] lArr [KEY_WORDS];
  logic [WORD_W-1:0] regA, regB, fillVal;
  logic [ADDR_W-1:0] iPtr;
  logic [JPTR_W-1:0] jPtr;

  logic [WORD_W-1:0] curS, curL, sumA, newA, sumB, newB, rotSum;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x,
                                             input logic [ROT_W-1:0] n);
    logic [2*WORD_W-1:0] wide;
    wide = {x, x} << n;
    return wide[2*WORD_W-1:WORD_W];
  endfunction

  // Operand selection for the current pointers
  always_comb begin
    curS = '0;
    for (int g = 0; g < TABLE_N; g++)
      if (iPtr == ADDR_W'(g)) curS = sTab[g];
    curL = '0;
    for (int k = 0; k < KEY_WORDS; k++)
      if (jPtr == JPTR_W'(k)) curL = lArr[k];
  end

  // One mixing iteration, both half-steps chained in the same cycle
  always_comb begin
    sumA   = curS + regA + regB;
    newA   = rotl(sumA, ROT_W'(3));
    sumB   = curL + newA + regB;
    rotSum = newA + regB;
    newB   = rotl(sumB, rotSum[ROT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < TABLE_N; g++) sTab[g] <= '0;
    end else begin
      for (int g = 0; g < TABLE_N; g++) begin
        if (strobe.initWr && iPtr == ADDR_W'(g))       sTab[g] <= fillVal;
        else if (strobe.mixStep && iPtr == ADDR_W'(g)) sTab[g] <= newA;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < KEY_WORDS; k++) lArr[k] <= '0;
    end else begin
      for (int k = 0; k < KEY_WORDS; k++) begin
        if (strobe.load)                                lArr[k] <= keyIn[k*WORD_W +: WORD_W];
        else if (strobe.mixStep && jPtr == JPTR_W'(k))  lArr[k] <= newB;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA    <= '0;
      regB    <= '0;
      fillVal <= P_CONST;
      iPtr    <= '0;
      jPtr    <= '0;
    end else if (strobe.load) begin
      regA    <= '0;
      regB    <= '0;
      fillVal <= P_CONST;
      iPtr    <= '0;
      jPtr    <= '0;
    end else if (strobe.initWr) begin
      fillVal <= fillVal + Q_CONST;
      iPtr    <= (iPtr == ADDR_W'(TABLE_N - 1)) ? '0 : iPtr + 1'b1;
    end else if (strobe.mixStep) begin
      regA <= newA;
      regB <= newB;
      iPtr <= (iPtr == ADDR_W'(TABLE_N - 1)) ? '0 : iPtr + 1'b1;
      jPtr <= (jPtr == JPTR_W'(KEY_WORDS - 1)) ? '0 : jPtr + 1'b1;
    end
  end

  // Read port: unused indices return zero
  always_comb begin
    rdData = '0;
    for (int g = 0; g < TABLE_N; g++)
      if (rdAddr == ADDR_W'(g)) rdData = sTab[g];
  end
endmodule

// File: rtl/rc5_key_expander.sv
module rc5_key_expander
  import rc5ks_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                setKey,
  input  logic [KEY_BITS-1:0] keyIn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [WORD_W-1:0]   rdData,
  output logic                ready
);
  ksStrobe_t strobe;

  rc5ks_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .setKey (setKey),
    .strobe (strobe),
    .ready  (ready)
  );

  rc5ks_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .keyIn  (keyIn),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );
endmodule

// File: rtl/rc5ks_checker.sv
module rc5ks_checker
  import rc5ks_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              setKey,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [WORD_W-1:0] rdData,
  input logic              ready
);
  localparam int CNT_W = $clog2(LATENCY + 2) + 1;

  // cycles since the last sampled strobe, frozen once ready
  logic [CNT_W-1:0] sinceKey;
  always_ff @(posedge clk) begin
    if (!rstN)                          sinceKey <= '0;
    else if (setKey)                    sinceKey <= CNT_W'(1);
    else if (sinceKey != '0 && !ready)  sinceKey <= sinceKey + 1'b1;
  end

  AST_READY_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (sinceKey == CNT_W'(LATENCY + 1))); // R5

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    setKey |=> !ready); // R7

  AST_DROP_ON_REKEY: assert property (@(posedge clk) disable iff (!rstN)
    (ready && setKey) |=> !ready); // R10

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !setKey) |=> ready); // R6

  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !setKey) |=> ($stable(rdAddr) -> $stable(rdData))); // R6

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr >= ADDR_W'(TABLE_N)) |-> (rdData == '0)); // R9
endmodule

bind rc5_key_expander rc5ks_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .setKey (setKey),
  .rdAddr (rdAddr),
  .rdData (rdData),
  .ready  (ready)
);

// File: tb/rc5_key_expander_tb.sv
`timescale 1ns/1ps
module rc5_key_expander_tb;
  localparam int NS = 26;
  localparam int LAT = 104;

  logic         clk = 1'b0;
  logic         rstN;
  logic         setKey;
  logic [127:0] keyIn;
  logic [4:0]   rdAddr;
  logic [31:0]  rdData;
  logic         ready;

  int checks = 0;
  int failures = 0;
  string phase = "R1";
  bit armed = 1'b0;

  // reference model state
  int unsigned expTable [NS];
  bit          tableKnown;
  bit          mReady;
  int          mCnt;
  logic [127:0] mKey;

  always #2 clk = ~clk;

  rc5_key_expander u_dut (
    .clk(clk), .rstN(rstN), .setKey(setKey), .keyIn(keyIn),
    .rdAddr(rdAddr), .rdData(rdData), .ready(ready)
  );

  function automatic int unsigned rotLeft(int unsigned v, int amount);
    int unsigned r = v;
    for (int s = 0; s < (amount % 32); s++) r = (r << 1) | (r >> 31);
    return r;
  endfunction

  task automatic buildTable(input logic [127:0] key);
    int unsigned lw [4];
    int unsigned a = 0, b = 0;
    int i = 0, j = 0;
    for (int k = 0; k < 4; k++) begin
      lw[k] = 0;
      for (int by = 3; by >= 0; by--) lw[k] = (lw[k] << 8) | int'(key[8*(4*k+by) +: 8]);
    end
    for (int n = 0; n < NS; n++) expTable[n] = 32'hB7E15163 + n * 32'h9E3779B9;
    for (int it = 0; it < 78; it++) begin
      a = rotLeft(expTable[i] + a + b, 3);
      expTable[i] = a;
      b = rotLeft(lw[j] + a + b, int'((a + b) & 31));
      lw[j] = b;
      i = (i + 1) % NS;
      j = (j + 1) % 4;
    end
  endtask

  // model advances at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mReady = 0; tableKnown = 1;
      for (int n = 0; n < NS; n++) expTable[n] = 0;
    end else if (setKey) begin
      mCnt = LAT; mReady = 0; mKey = keyIn; tableKnown = 0;
    end else if (mCnt != 0) begin
      mCnt = mCnt - 1;
      if (mCnt == 0) begin
        mReady = 1;
        buildTable(mKey);
        tableKnown = 1;
      end
    end
  end

  // compare at the falling edge, inputs change 1 ns later
  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (ready !== mReady) begin
        failures++;
        $display("FAIL %s ready actual=%0b expected=%0b", phase, ready, mReady);
      end
      if (rdAddr >= 5'd26) begin
        checks++;
        if (rdData !== 32'h0) begin
          failures++;
          $display("FAIL R9 rdData[%0d] actual=%h expected=00000000", rdAddr, rdData);
        end
      end else if (tableKnown) begin
        checks++;
        if (rdData !== expTable[rdAddr]) begin
          failures++;
          $display("FAIL %s rdData[%0d] actual=%h expected=%h", phase, rdAddr, rdData, expTable[rdAddr]);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic strobeKey(input logic [127:0] key);
    @(negedge clk); #1;
    setKey = 1'b1; keyIn = key;
    @(negedge clk); #1;
    setKey = 1'b0;
  endtask

  task automatic sweep();
    for (int a = 0; a < 32; a++) begin
      @(negedge clk); #1;
      rdAddr = 5'(a);
    end
    tick(1);
  endtask

  initial begin
    rstN = 1'b0; setKey = 1'b0; keyIn = '0; rdAddr = '0;
    tick(3);
    rstN = 1'b1;
    armed = 1'b1;
    phase = "R1";
    sweep();

    phase = "R2 R3 R4 R5";
    strobeKey(128'h0f0e0d0c_0b0a0908_07060504_03020100);
    tick(LAT + 4);
    sweep();

    phase = "R6";
    rdAddr = 5'd13;
    tick(20);
    sweep();

    phase = "R7";
    strobeKey(128'hffffffff_00000000_deadbeef_12345678);
    tick(10);                       // abort during fill
    strobeKey(128'h91d3_5c7e_a0b2_4f66_1234_abcd_0000_ffff);
    tick(60);                       // abort during mixing
    strobeKey(128'h00000000_00000000_00000000_00000001);
    tick(LAT + 4);
    sweep();

    phase = "R8";
    strobeKey(128'h2b7e1516_28aed2a6_abf71588_09cf4f3c);
    for (int c = 0; c < LAT + 4; c++) begin
      @(negedge clk); #1;
      keyIn = {$urandom, $urandom, $urandom, $urandom};
    end
    sweep();

    phase = "R10";
    strobeKey('0);
    tick(LAT + 4);
    sweep();

    armed = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule